// File: doc/BRIEF.md
# Current-Transformer Compensator Bypass and Health Supervisor

This block decides when a series voltage compensator is switched into a current-transformer secondary loop, and it watches the compensator for faults. It takes signed samples of the secondary current and compares their magnitude with a nominal-current threshold. It declares a transient only after a fixed run of consecutive over-threshold samples. When that happens, it opens the normally-closed bypass contact and enables the bridge switches in the same clock cycle. It removes the compensator again only after a programmable run of consecutive samples at or below the threshold.

Each sample also carries a digitised measurement of the compensator output voltage and the reference voltage that was commanded. While the compensator is bypassed, the expected output is zero. While it is inserted, the expected output is the reference. A difference outside a programmable tolerance band that lasts for a programmable number of samples counts as an equipment failure. The contact and the bridge back each other up. A failure found while bypassed means the contact has failed open, so the bridge is switched on to short the loop. A failure found while compensating closes the contact and turns the bridge off. Either way a sticky alarm is raised, and it stays until an external clear pulse.

Top module: `ctbs_bypass_supervisor`

## Requirements
- R1: After reset, bypass_open, bridge_en, force_short, fault_det and equip_alarm are all 0.
- R2: fault_det rises on the clock edge that captures the 16th consecutive valid sample whose two's-complement magnitude is strictly greater than thresh. A sample whose magnitude equals or is below thresh restarts the run. The most negative code counts with its full magnitude.
- R3: While no transient is flagged and no alarm is raised, bypass_open and bridge_en both stay 0.
- R4: bypass_open and bridge_en rise together one clock after fault_det rises. bypass_open is never 1 while bridge_en is 0.
- R5: Once flagged, fault_det falls on the edge that captures the release_lim-th consecutive valid sample at or below thresh (a release_lim of 0 acts as 1). bypass_open and bridge_en fall one clock later.
- R6: While bypassed, persist_lim consecutive samples with |v_meas| > tol cause a failure. The block then enters a latched short state with force_short=1, bridge_en=1, bypass_open=0 and equip_alarm=1.
- R7: While inserted, persist_lim consecutive samples with |v_meas - v_ref| > tol cause a failure. The block then enters a latched state with bypass_open=0, bridge_en=0, force_short=0 and equip_alarm=1.
- R8: A difference exactly equal to tol is inside the band. Any in-band sample restarts the mismatch run, so a shorter run raises no alarm. A persist_lim of 0 acts as 1.
- R9: equip_alarm and the latched drive state hold, whatever the current samples do, until alarm_clr is seen high. The block then returns to the bypassed idle state with the alarm cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Marks a new sample on the data inputs |
| smp_i | input | SMP_W | Signed secondary-current sample |
| thresh | input | SMP_W | Unsigned nominal-current threshold |
| v_meas | input | V_W | Signed measured compensator output voltage |
| v_ref | input | V_W | Signed commanded reference voltage |
| tol | input | V_W | Unsigned tolerance band for the voltage comparison |
| persist_lim | input | CNT_W | Consecutive mismatching samples needed for a failure |
| release_lim | input | CNT_W | Consecutive low samples needed to drop the transient flag |
| alarm_clr | input | 1 | Clears the latched alarm and the failure state |
| bypass_open | output | 1 | 1 commands the normally-closed bypass contact open |
| bridge_en | output | 1 | Enables the bridge switches |
| force_short | output | 1 | Bridge commanded to short the secondary loop |
| fault_det | output | 1 | Transient declared |
| equip_alarm | output | 1 | Sticky equipment-failure alarm |

## Verification
The hardest state to reach is the failure found during compensation. It needs a full 16-sample over-threshold run to insert the compensator first, and then a mismatch run against a non-zero reference while the current stays above the threshold, so that the block does not drop back to bypass before the failure latches. The bench builds each such scenario from a fresh reset. It sweeps the run lengths around each limit, and also the differences on and next to the tolerance edge in both signs. It then checks that the latched state survives further transients until the clear pulse arrives.

// File: rtl/ctbs_pkg.sv
package ctbs_pkg;

    localparam int SMP_W_DEF    = 16;
    localparam int V_W_DEF      = 16;
    localparam int CNT_W_DEF    = 8;
    localparam int TRIP_RUN_DEF = 16;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,   // bypassed, bridge off
        ST_INSERT = 2'd1,   // contact open, bridge compensating
        ST_SHORT  = 2'd2,   // contact failed open, bridge shorts loop
        ST_REBYP  = 2'd3    // compensator failed, contact reclosed
    } seq_st_e;

    typedef struct packed {
        logic bypass_open;
        logic bridge_en;
        logic force_short;
    } drive_t;

    function automatic drive_t drive_of(input seq_st_e st);
        drive_t d;
        d = '0;
        case (st)
            ST_INSERT: begin
                d.bypass_open = 1'b1;
                d.bridge_en   = 1'b1;
            end
            ST_SHORT: begin
                d.bridge_en   = 1'b1;
                d.force_short = 1'b1;
            end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/ctbs_detect.sv
module ctbs_detect
    import ctbs_pkg::*;
#(
    parameter int SMP_W    = SMP_W_DEF,
    parameter int CNT_W    = CNT_W_DEF,
    parameter int TRIP_RUN = TRIP_RUN_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_i,
    input  logic        [SMP_W-1:0] thresh,
    input  logic        [CNT_W-1:0] release_lim,
    output logic                    fault_det
);
    localparam logic [CNT_W:0] TRIP_L = (CNT_W+1)'(TRIP_RUN);
    localparam logic [CNT_W:0] ONE_C  = (CNT_W+1)'(1);
    localparam logic [SMP_W:0] ONE_S  = (SMP_W+1)'(1);

    logic [SMP_W:0]   mag;
    logic             above;
    logic [CNT_W-1:0] hi_run, lo_run, hi_sat, lo_sat, rel_eff;
    logic [CNT_W:0]   hi_inc, lo_inc;

    always_comb begin
        mag     = smp_i[SMP_W-1] ? ({1'b0, ~smp_i} + ONE_S) : {1'b0, smp_i};
        above   = mag > {1'b0, thresh};
        hi_inc  = {1'b0, hi_run} + ONE_C;
        lo_inc  = {1'b0, lo_run} + ONE_C;
        hi_sat  = (hi_inc >= TRIP_L) ? TRIP_L[CNT_W-1:0] : hi_inc[CNT_W-1:0];
        lo_sat  = lo_inc[CNT_W] ? lo_run : lo_inc[CNT_W-1:0];
        rel_eff = (release_lim == '0) ? CNT_W'(1) : release_lim;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run    <= '0;
            lo_run    <= '0;
            fault_det <= 1'b0;
        end else if (smp_valid) begin
            if (above) begin
                lo_run <= '0;
                hi_run <= hi_sat;
                if (hi_inc >= TRIP_L)
                    fault_det <= 1'b1;
            end else begin
                hi_run <= '0;
                lo_run <= lo_sat;
                if (lo_inc >= {1'b0, rel_eff})
                    fault_det <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ctbs_health.sv
module ctbs_health
    import ctbs_pkg::*;
#(
    parameter int V_W   = V_W_DEF,
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  smp_valid,
    input  seq_st_e               st,
    input  logic signed [V_W-1:0] v_meas,
    input  logic signed [V_W-1:0] v_ref,
    input  logic        [V_W-1:0] tol,
    input  logic      [CNT_W-1:0] persist_lim,
    output logic                  fail_q
);
    localparam logic [V_W:0]   ONE_V = (V_W+1)'(1);
    localparam logic [CNT_W:0] ONE_C = (CNT_W+1)'(1);

    logic signed [V_W-1:0] exp_v;
    logic signed [V_W:0]   diff;
    logic        [V_W:0]   dmag;
    logic                  out_band, active, mode_chg;
    logic      [CNT_W-1:0] cnt, cnt_base, cnt_sat, per_eff;
    logic        [CNT_W:0] cnt_inc;
    seq_st_e               prev_st;

    always_comb begin
        exp_v    = (st == ST_INSERT) ? v_ref : '0;
        diff     = $signed({v_meas[V_W-1], v_meas}) - $signed({exp_v[V_W-1], exp_v});
        dmag     = diff[V_W] ? ($unsigned(~diff) + ONE_V) : $unsigned(diff);
        out_band = dmag > {1'b0, tol};
        active   = (st == ST_IDLE) || (st == ST_INSERT);
        mode_chg = (st != prev_st);
        cnt_base = mode_chg ? '0 : cnt;
        cnt_inc  = {1'b0, cnt_base} + ONE_C;
        cnt_sat  = cnt_inc[CNT_W] ? cnt_base : cnt_inc[CNT_W-1:0];
        per_eff  = (persist_lim == '0) ? CNT_W'(1) : persist_lim;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            fail_q  <= 1'b0;
            prev_st <= ST_IDLE;
        end else begin
            prev_st <= st;
            fail_q  <= 1'b0;
            if (!active) begin
                cnt <= '0;
            end else if (smp_valid) begin
                if (out_band) begin
                    cnt <= cnt_sat;
                    if (cnt_inc >= {1'b0, per_eff})
                        fail_q <= 1'b1;
                end else begin
                    cnt <= '0;
                end
            end else begin
                cnt <= cnt_base;
            end
        end
    end

endmodule

// File: rtl/ctbs_seq.sv
module ctbs_seq
    import ctbs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    fault_det,
    input  logic    hlth_fail,
    input  logic    alarm_clr,
    output seq_st_e st,
    output logic    equip_alarm,
    output drive_t  drv
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            equip_alarm <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (hlth_fail) begin
                        st          <= ST_SHORT;
                        equip_alarm <= 1'b1;
                    end else if (fault_det) begin
                        st <= ST_INSERT;
                    end
                end
                ST_INSERT: begin
                    if (hlth_fail) begin
                        st          <= ST_REBYP;
                        equip_alarm <= 1'b1;
                    end else if (!fault_det) begin
                        st <= ST_IDLE;
                    end
                end
                default: begin
                    if (alarm_clr) begin
                        st          <= ST_IDLE;
                        equip_alarm <= 1'b0;
                    end
                end
            endcase
        end
    end

    always_comb drv = drive_of(st);

endmodule

// File: rtl/ctbs_bypass_supervisor.sv
module ctbs_bypass_supervisor
    import ctbs_pkg::*;
#(
    parameter int SMP_W    = SMP_W_DEF,
    parameter int V_W      = V_W_DEF,
    parameter int CNT_W    = CNT_W_DEF,
    parameter int TRIP_RUN = TRIP_RUN_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_i,
    input  logic        [SMP_W-1:0] thresh,
    input  logic signed   [V_W-1:0] v_meas,
    input  logic signed   [V_W-1:0] v_ref,
    input  logic          [V_W-1:0] tol,
    input  logic        [CNT_W-1:0] persist_lim,
    input  logic        [CNT_W-1:0] release_lim,
    input  logic                    alarm_clr,
    output logic                    bypass_open,
    output logic                    bridge_en,
    output logic                    force_short,
    output logic                    fault_det,
    output logic                    equip_alarm
);
    seq_st_e st;
    drive_t  drv;
    logic    hlth_fail;

    ctbs_detect #(.SMP_W(SMP_W), .CNT_W(CNT_W), .TRIP_RUN(TRIP_RUN)) u_det (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_i(smp_i),
        .thresh(thresh), .release_lim(release_lim), .fault_det(fault_det)
    );

    ctbs_health #(.V_W(V_W), .CNT_W(CNT_W)) u_hlth (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .st(st),
        .v_meas(v_meas), .v_ref(v_ref), .tol(tol),
        .persist_lim(persist_lim), .fail_q(hlth_fail)
    );

    ctbs_seq u_seq (
        .clk(clk), .rst(rst), .fault_det(fault_det), .hlth_fail(hlth_fail),
        .alarm_clr(alarm_clr), .st(st), .equip_alarm(equip_alarm), .drv(drv)
    );

    assign bypass_open = drv.bypass_open;
    assign bridge_en   = drv.bridge_en;
    assign force_short = drv.force_short;

endmodule

// File: rtl/ctbs_chk.sv
module ctbs_chk (
    input logic clk,
    input logic rst,
    input logic smp_valid,
    input logic alarm_clr,
    input logic bypass_open,
    input logic bridge_en,
    input logic force_short,
    input logic fault_det,
    input logic equip_alarm,
    input logic hlth_fail
);
    // R4
    open_needs_bridge_chk: assert property (@(posedge clk) disable iff (rst)
        bypass_open |-> bridge_en);

    // R4
    insert_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bypass_open) |-> $past(fault_det));

    // R2
    det_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_det) |-> $past(smp_valid));

    // R6
    short_drive_chk: assert property (@(posedge clk) disable iff (rst)
        force_short |-> (bridge_en && !bypass_open && equip_alarm));

    // R7
    alarm_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(equip_alarm) |-> $past(hlth_fail));

    // R9
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (equip_alarm && !alarm_clr) |=> equip_alarm);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!fault_det && !equip_alarm && !bypass_open && !$past(fault_det)) |-> !bridge_en);

endmodule

bind ctbs_bypass_supervisor ctbs_chk u_chk (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .alarm_clr(alarm_clr),
    .bypass_open(bypass_open), .bridge_en(bridge_en), .force_short(force_short),
    .fault_det(fault_det), .equip_alarm(equip_alarm), .hlth_fail(hlth_fail)
);

// File: tb/sim_ctbs_bypass_supervisor.sv
module sim_ctbs_bypass_supervisor;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0;
    logic signed [15:0] smp_i = '0;
    logic [15:0] thresh = 16'd1000;
    logic signed [15:0] v_meas = '0;
    logic signed [15:0] v_ref = '0;
    logic [15:0] tol = 16'd20;
    logic [7:0] persist_lim = 8'd4;
    logic [7:0] release_lim = 8'd3;
    logic alarm_clr = 1'b0;
    logic bypass_open, bridge_en, force_short, fault_det, equip_alarm;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ctbs_bypass_supervisor u0 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_i(smp_i),
        .thresh(thresh), .v_meas(v_meas), .v_ref(v_ref), .tol(tol),
        .persist_lim(persist_lim), .release_lim(release_lim),
        .alarm_clr(alarm_clr), .bypass_open(bypass_open), .bridge_en(bridge_en),
        .force_short(force_short), .fault_det(fault_det), .equip_alarm(equip_alarm)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smp_valid = 1'b0; smp_i = '0; v_meas = '0; v_ref = '0;
        thresh = 16'd1000; tol = 16'd20; persist_lim = 8'd4; release_lim = 8'd3;
        alarm_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // one sample, then settle two cycles (caller is at a negedge)
    task automatic send(input int s, input int vm, input int vr);
        smp_i = 16'(s); v_meas = 16'(vm); v_ref = 16'(vr); smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic insert_comp();
        for (int i = 0; i < 16; i++) send(1500, 0, 0);
    endtask

    task automatic check_idle(input string tag);
        chk({tag, " bypass_open"}, int'(bypass_open), 0);
        chk({tag, " bridge_en"}, int'(bridge_en), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 bypass_open", int'(bypass_open), 0);
        chk("R1 bridge_en", int'(bridge_en), 0);
        chk("R1 force_short", int'(force_short), 0);
        chk("R1 fault_det", int'(fault_det), 0);
        chk("R1 equip_alarm", int'(equip_alarm), 0);

        // R2 run-length sweep, alternating signs
        for (int k = 10; k <= 20; k++) begin
            do_reset();
            for (int i = 0; i < k; i++)
                send(((i % 2) == 0) ? (1001 + k) : -(1001 + k), 0, 0);
            chk($sformatf("R2 run=%0d fault_det", k), int'(fault_det), (k >= 16) ? 1 : 0);
            chk($sformatf("R2 run=%0d bypass_open", k), int'(bypass_open), (k >= 16) ? 1 : 0);
        end

        // R2 sample equal to threshold restarts the run
        do_reset();
        for (int i = 0; i < 15; i++) send(-1001, 0, 0);
        send(1000, 0, 0);
        for (int i = 0; i < 15; i++) send(1001, 0, 0);
        chk("R2 equal restarts", int'(fault_det), 0);
        send(1001, 0, 0);
        chk("R2 after restart 16th", int'(fault_det), 1);

        // R2 most negative code vs largest positive threshold
        do_reset();
        thresh = 16'd32767;
        for (int i = 0; i < 16; i++) send(32767, 0, 0);
        chk("R2 max positive not above", int'(fault_det), 0);
        for (int i = 0; i < 16; i++) send(-32768, 0, 0);
        chk("R2 most negative above", int'(fault_det), 1);

        // R3 sub-threshold traffic keeps compensator out
        do_reset();
        for (int i = 0; i < 30; i++) send((i % 3 == 0) ? -1000 : 999 - i, 0, 0);
        check_idle("R3");
        chk("R3 fault_det", int'(fault_det), 0);

        // R4 same-cycle insertion, one clock after the flag
        do_reset();
        for (int i = 0; i < 15; i++) send(2000, 0, 0);
        smp_i = 16'sd2000; smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R4 flag first", int'(fault_det), 1);
        chk("R4 contact still closed", int'(bypass_open), 0);
        chk("R4 bridge still off", int'(bridge_en), 0);
        @(negedge clk);
        chk("R4 contact open", int'(bypass_open), 1);
        chk("R4 bridge on", int'(bridge_en), 1);

        // R5 release sweep
        for (int r = 0; r <= 4; r++) begin
            do_reset();
            release_lim = 8'(r);
            insert_comp();
            for (int i = 1; i <= ((r == 0) ? 1 : r); i++) begin
                send(500, 0, 0);
                chk($sformatf("R5 lim=%0d low=%0d fault_det", r, i), int'(fault_det),
                    (i >= ((r == 0) ? 1 : r)) ? 0 : 1);
                chk($sformatf("R5 lim=%0d low=%0d bypass_open", r, i), int'(bypass_open),
                    (i >= ((r == 0) ? 1 : r)) ? 0 : 1);
            end
            chk($sformatf("R5 lim=%0d bridge off", r), int'(bridge_en), 0);
        end

        // R6 normal-mode failure, run-length sweep
        for (int n = 1; n <= 6; n++) begin
            do_reset();
            for (int i = 0; i < n; i++) send(0, ((i % 2) == 0) ? 100 : -100, 0);
            send(0, 0, 0);
            chk($sformatf("R6 run=%0d alarm", n), int'(equip_alarm), (n >= 4) ? 1 : 0);
            chk($sformatf("R6 run=%0d force_short", n), int'(force_short), (n >= 4) ? 1 : 0);
            chk($sformatf("R6 run=%0d bridge_en", n), int'(bridge_en), (n >= 4) ? 1 : 0);
            chk($sformatf("R6 run=%0d bypass_open", n), int'(bypass_open), 0);
        end

        // R8 tolerance edge, persist_lim 0 acts as 1
        do_reset();
        persist_lim = 8'd0;
        send(0, 20, 0);
        send(0, -20, 0);
        chk("R8 diff==tol in band", int'(equip_alarm), 0);
        send(0, -21, 0);
        chk("R8 diff==tol+1 out of band", int'(equip_alarm), 1);

        // R8 interrupted mismatch run
        do_reset();
        for (int i = 0; i < 3; i++) send(0, 60, 0);
        send(0, 5, 0);
        for (int i = 0; i < 3; i++) send(0, 60, 0);
        chk("R8 interrupted run", int'(equip_alarm), 0);

        // R7 compensation-mode failure; in-band tracking first
        do_reset();
        persist_lim = 8'd2;
        insert_comp();
        for (int i = 0; i < 4; i++) send(1500, 520, 500);
        for (int i = 0; i < 4; i++) send(-1500, -520, -500);
        chk("R7 in-band tracking alarm", int'(equip_alarm), 0);
        chk("R7 still inserted", int'(bypass_open), 1);
        send(1500, 521, 500);
        chk("R7 one mismatch", int'(equip_alarm), 0);
        send(1500, 479, 500);
        chk("R7 alarm", int'(equip_alarm), 1);
        chk("R7 contact reclosed", int'(bypass_open), 0);
        chk("R7 bridge off", int'(bridge_en), 0);
        chk("R7 no short", int'(force_short), 0);

        // R9 latched state ignores transients and mismatches until cleared
        for (int i = 0; i < 20; i++) send(3000, 0, 0);
        chk("R9 alarm held", int'(equip_alarm), 1);
        chk("R9 contact held closed", int'(bypass_open), 0);
        chk("R9 bridge held off", int'(bridge_en), 0);
        release_lim = 8'd1;
        send(0, 0, 0);
        alarm_clr = 1'b1;
        @(negedge clk);
        alarm_clr = 1'b0;
        @(negedge clk);
        chk("R9 alarm cleared", int'(equip_alarm), 0);
        check_idle("R9 after clear");

        // R9 short state also latched
        do_reset();
        persist_lim = 8'd1;
        send(0, 300, 0);
        for (int i = 0; i < 5; i++) send(0, 0, 0);
        chk("R9 short held", int'(force_short), 1);
        alarm_clr = 1'b1;
        @(negedge clk);
        alarm_clr = 1'b0;
        @(negedge clk);
        chk("R9 short released", int'(force_short), 0);
        chk("R9 alarm off", int'(equip_alarm), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule